// File: doc/BRIEF.md
# Configuration Space Register Target

This block is the configuration register file of a bus device with one or several functions. A host-side agent presents simplified configuration accesses to it. Each access carries a select strobe, a two-bit cycle type, a function number, a dword register index, byte enables and, for writes, data. Every function owns a private 256-byte space. The first 64 bytes form the standard header: identity, command, class code, header type, one memory base address register, subsystem identity and the interrupt routing bytes. The bytes above that form the device-dependent region, which holds the firmware path for loading the subsystem vendor ID.

The target claims an access only when the select strobe is high, the cycle type is 00 and the function number names a function that exists. As a result the device appears at exactly one location per function. A claimed access is answered one clock later with a response strobe; read data comes with it. The subsystem vendor ID is read-only at its header position. A parameter picks how firmware may change it. In shadow mode, a copy in the device-dependent region can be written, and each write there also updates the header field. In write-enable mode, a control bit in the device-dependent region opens the header field for writes while the bit is set.

Top module: `cfg_space_target`

## Requirements
- R1: An access is claimed only when `cfg_req`, `cfg_idsel` and `cfg_type == 2'b00` are all true. An unclaimed access gives no response strobe, returns zero data and changes no register.
- R2: With `NUM_FUNC > 1`, function numbers below `NUM_FUNC` are claimed and all others are not. With `NUM_FUNC == 1`, only function 0 is claimed. Header byte 0Eh bit 7 (dword 3, bit 23) reads 1 exactly when `NUM_FUNC > 1`.
- R3: Dword 0 reads {device ID, vendor ID}. Dword 2 reads {24-bit class code, revision}. Dword 3 reads only the header-type byte. Writes to these dwords have no effect.
- R4: Every dword not listed in another requirement reads zero. This includes dwords 5 to 9, the unused base address slots. Writes to those dwords are dropped.
- R5: The base address register at dword 4 accepts any 32-bit value in its bits above `BAR_LOG2`. Its lower `BAR_LOG2` bits always read zero, which encodes a 32-bit, non-prefetchable memory window. It resets to zero.
- R6: The command field (dword 1, bits 15:0) resets to zero. Only bits 0, 1, 2, 6, 8 and 10 (mask 0547h) are writable, and they follow the byte enables. Each function has its own copy, and a write to one function leaves every other function unchanged.
- R7: The interrupt line byte (dword 15, bits 7:0) is read/write and resets to FFh. The interrupt pin byte (bits 15:8) is read-only and equals (function mod 4) + 1.
- R8: Dword 11 reads {subsystem ID, subsystem vendor ID}. Both reset to the non-zero parameter values. The subsystem ID never changes. In shadow mode, a write to dword 11 has no effect.
- R9: In shadow mode, dword `SVID_IDX` (default 16, byte 40h) reads {16'h0, subsystem vendor ID}. A write to its bytes 0 and 1 updates both that copy and dword 11 bits 15:0.
- R10: In write-enable mode, bit 0 of dword `SVID_IDX` is an enable that resets to 0. While the enable is 1, writes to dword 11 bytes 0 and 1 change the subsystem vendor ID. While it is 0, such writes are ignored.
- R11: A claimed access raises `rsp_valid` for one cycle on the clock edge after the request. For a read, `rsp_rdata` carries the register value from before that edge. For a write, and whenever `rsp_valid` is low, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Access request strobe |
| cfg_idsel | input | 1 | Device select strobe |
| cfg_type | input | 2 | Cycle type; 00 is the local type |
| cfg_func | input | 3 | Function number |
| cfg_reg | input | 6 | Dword register index |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_be | input | 4 | Byte enables for write data |
| cfg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Access was claimed (one cycle later) |
| rsp_rdata | output | 32 | Read data, zero otherwise |

## Verification
The bench sweeps every combination of select, cycle type and function number. A decoder that ignored the cycle type or the function bits would answer at several locations, and the bench would see a response where none is expected. It writes ones and a mixed pattern to all 64 dwords of one function, then reads back every dword of both functions. This catches a read-only field that accepts writes, a reserved dword that keeps data, and a command register shared between functions. Byte-enable sweeps on the command, base address, interrupt and shadow dwords expose lane mix-ups. On the write-enable variant, the bench writes the subsystem vendor ID while the enable is set and again while it is clear, which shows whether the lock works in both states.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [0:0] {
    SVID_SHADOW = 1'b0,
    SVID_WREN   = 1'b1
  } svid_mode_e;

  localparam logic [5:0] IDX_ID     = 6'd0;
  localparam logic [5:0] IDX_CMD    = 6'd1;
  localparam logic [5:0] IDX_CLASS  = 6'd2;
  localparam logic [5:0] IDX_HDR    = 6'd3;
  localparam logic [5:0] IDX_BAR0   = 6'd4;
  localparam logic [5:0] IDX_SUBSYS = 6'd11;
  localparam logic [5:0] IDX_INTR   = 6'd15;

  localparam logic [15:0] CMD_WMASK = 16'h0547;

  // Replace the enabled byte lanes of old_v with those of new_v.
  function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                           input logic [31:0] new_v,
                                           input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int b = 0; b < 4; b++) begin
      if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
    end
    return r;
  endfunction

  // Bits of the base address register that software may write.
  function automatic logic [31:0] bar_keep(input int lg);
    return ~((32'd1 << lg) - 32'd1);
  endfunction

  // Local configuration cycle addressed to this device.
  function automatic logic type0_hit(input logic sel, input logic [1:0] typ);
    return sel && (typ == 2'b00);
  endfunction

  // Function number acceptance: full decode only when multifunction.
  function automatic logic func_hit(input logic [2:0] fn, input int nfunc);
    if (nfunc > 1) return ({29'd0, fn} < 32'(nfunc));
    return fn == 3'd0;
  endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode #(
  parameter int NUM_FUNC = 2
) (
  input  logic                cfg_req,
  input  logic                cfg_idsel,
  input  logic [1:0]          cfg_type,
  input  logic [2:0]          cfg_func,
  output logic                claim,
  output logic [NUM_FUNC-1:0] hit_vec
);
  import cfg_pkg::*;

  assign claim = cfg_req && type0_hit(cfg_idsel, cfg_type) &&
                 func_hit(cfg_func, NUM_FUNC);

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_hit
    assign hit_vec[f] = claim && (cfg_func == 3'(f));
  end

endmodule

// File: rtl/cfg_func_regs.sv
module cfg_func_regs #(
  parameter int                  FUNC_NUM   = 0,
  parameter bit                  MULTI      = 1'b0,
  parameter logic [15:0]         VENDOR_ID  = 16'h1D5A,
  parameter logic [15:0]         DEVICE_ID  = 16'h0C31,
  parameter logic [7:0]          REV_ID     = 8'h02,
  parameter logic [23:0]         CLASS_CODE = 24'h078000,
  parameter logic [15:0]         SSVID_RST  = 16'h1D5A,
  parameter logic [15:0]         SSID       = 16'hA001,
  parameter int                  BAR_LOG2   = 12,
  parameter cfg_pkg::svid_mode_e SVID_MODE  = cfg_pkg::SVID_SHADOW,
  parameter logic [5:0]          SVID_IDX   = 6'd16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hit,
  input  logic        we,
  input  logic [5:0]  idx,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [15:0] cmd_q,
  output logic [15:0] svid_q,
  output logic        svid_upd
);
  import cfg_pkg::*;

  localparam logic [31:0] BAR_MASK = bar_keep(BAR_LOG2);
  localparam logic [7:0]  HDR_TYPE = {MULTI, 7'h00};
  localparam logic [7:0]  INT_PIN  = 8'((FUNC_NUM % 4) + 1);

  logic        wr;
  logic [31:0] bar_q;
  logic [7:0]  intl_q;
  logic        wen_q;
  logic [31:0] aux_rd;
  logic [31:0] cmd_merged;
  logic [31:0] svid_merged;

  assign wr          = hit && we;
  assign cmd_merged  = be_merge({16'h0000, cmd_q}, wdata, be);
  assign svid_merged = be_merge({16'h0000, svid_q}, wdata, be);

  // Command register: only the implemented control bits are kept.
  always_ff @(posedge clk) begin
    if (!rst_n)                    cmd_q <= 16'h0000;
    else if (wr && idx == IDX_CMD) cmd_q <= cmd_merged[15:0] & CMD_WMASK;
  end

  // Base address register with hardwired size/type bits.
  always_ff @(posedge clk) begin
    if (!rst_n)                     bar_q <= 32'h0;
    else if (wr && idx == IDX_BAR0) bar_q <= be_merge(bar_q, wdata, be) & BAR_MASK;
  end

  // Interrupt line byte.
  always_ff @(posedge clk) begin
    if (!rst_n)                              intl_q <= 8'hFF;
    else if (wr && idx == IDX_INTR && be[0]) intl_q <= wdata[7:0];
  end

  // Subsystem vendor ID register, updated only through the selected path.
  always_ff @(posedge clk) begin
    if (!rst_n)        svid_q <= SSVID_RST;
    else if (svid_upd) svid_q <= svid_merged[15:0];
  end

  if (SVID_MODE == SVID_WREN) begin : g_wren
    always_ff @(posedge clk) begin
      if (!rst_n)                              wen_q <= 1'b0;
      else if (wr && idx == SVID_IDX && be[0]) wen_q <= wdata[0];
    end
    assign svid_upd = wr && (idx == IDX_SUBSYS) && wen_q && (be[1] || be[0]);
    assign aux_rd   = {31'h0, wen_q};
  end else begin : g_shadow
    assign wen_q    = 1'b0;
    assign svid_upd = wr && (idx == SVID_IDX) && (be[1] || be[0]);
    assign aux_rd   = {16'h0000, svid_q};
  end

  // Read multiplexer; every unlisted index returns zero.
  always_comb begin
    rdata = 32'h0;
    if (idx == SVID_IDX) begin
      rdata = aux_rd;
    end else begin
      case (idx)
        IDX_ID:     rdata = {DEVICE_ID, VENDOR_ID};
        IDX_CMD:    rdata = {16'h0000, cmd_q};
        IDX_CLASS:  rdata = {CLASS_CODE, REV_ID};
        IDX_HDR:    rdata = {8'h00, HDR_TYPE, 16'h0000};
        IDX_BAR0:   rdata = bar_q;
        IDX_SUBSYS: rdata = {SSID, svid_q};
        IDX_INTR:   rdata = {16'h0000, INT_PIN, intl_q};
        default:    rdata = 32'h0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target #(
  parameter int                  NUM_FUNC   = 2,
  parameter logic [15:0]         VENDOR_ID  = 16'h1D5A,
  parameter logic [15:0]         DEVICE_ID  = 16'h0C31,
  parameter logic [7:0]          REV_ID     = 8'h02,
  parameter logic [23:0]         CLASS_CODE = 24'h078000,
  parameter logic [15:0]         SSVID_RST  = 16'h1D5A,
  parameter logic [15:0]         SSID       = 16'hA001,
  parameter int                  BAR_LOG2   = 12,
  parameter cfg_pkg::svid_mode_e SVID_MODE  = cfg_pkg::SVID_SHADOW,
  parameter logic [5:0]          SVID_IDX   = 6'd16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_req,
  input  logic        cfg_idsel,
  input  logic [1:0]  cfg_type,
  input  logic [2:0]  cfg_func,
  input  logic [5:0]  cfg_reg,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  localparam bit MULTI = (NUM_FUNC > 1);

  logic                   claim;
  logic [NUM_FUNC-1:0]    hit_vec;
  logic [NUM_FUNC-1:0]    svid_upd;
  logic [NUM_FUNC*16-1:0] svid_flat;
  logic [NUM_FUNC*16-1:0] cmd_flat;
  logic [31:0]            rd_fn [NUM_FUNC];
  logic [31:0]            rd_sel;

  cfg_decode #(.NUM_FUNC(NUM_FUNC)) u_dec (
    .cfg_req   (cfg_req),
    .cfg_idsel (cfg_idsel),
    .cfg_type  (cfg_type),
    .cfg_func  (cfg_func),
    .claim     (claim),
    .hit_vec   (hit_vec)
  );

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
    cfg_func_regs #(
      .FUNC_NUM   (f),
      .MULTI      (MULTI),
      .VENDOR_ID  (VENDOR_ID),
      .DEVICE_ID  (DEVICE_ID),
      .REV_ID     (REV_ID),
      .CLASS_CODE (CLASS_CODE),
      .SSVID_RST  (SSVID_RST),
      .SSID       (SSID),
      .BAR_LOG2   (BAR_LOG2),
      .SVID_MODE  (SVID_MODE),
      .SVID_IDX   (SVID_IDX)
    ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_vec[f]),
      .we       (cfg_we),
      .idx      (cfg_reg),
      .be       (cfg_be),
      .wdata    (cfg_wdata),
      .rdata    (rd_fn[f]),
      .cmd_q    (cmd_flat[16*f +: 16]),
      .svid_q   (svid_flat[16*f +: 16]),
      .svid_upd (svid_upd[f])
    );
  end

  // One-hot select of the addressed function's read data.
  always_comb begin
    rd_sel = 32'h0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      if (hit_vec[f]) rd_sel = rd_sel | rd_fn[f];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= claim;
      rsp_rdata <= (claim && !cfg_we) ? rd_sel : 32'h0;
    end
  end

endmodule

// File: rtl/cfg_space_checker.sv
module cfg_space_checker #(
  parameter int NUM_FUNC = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_req,
  input logic                   cfg_idsel,
  input logic [1:0]             cfg_type,
  input logic [2:0]             cfg_func,
  input logic                   cfg_we,
  input logic                   rsp_valid,
  input logic [31:0]            rsp_rdata,
  input logic [NUM_FUNC-1:0]    hit_vec,
  input logic [NUM_FUNC-1:0]    svid_upd,
  input logic [NUM_FUNC*16-1:0] svid_flat,
  input logic [NUM_FUNC*16-1:0] cmd_flat
);
  localparam logic [3:0] NF = 4'(NUM_FUNC);

  logic req_local;
  logic fn_exists;
  assign req_local = cfg_req && cfg_idsel && (cfg_type == 2'b00);
  assign fn_exists = (NUM_FUNC > 1) ? ({1'b0, cfg_func} < NF) : (cfg_func == 3'd0);

  AST_TYPE1_NOT_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_type != 2'b00) |=> !rsp_valid); // R1
  AST_NO_SELECT_NOT_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_idsel) |=> !rsp_valid); // R1
  AST_FUNC_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_local && !fn_exists) |=> !rsp_valid); // R2
  AST_SINGLE_FUNC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_CMD_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_vec[0] |=> $stable(cmd_flat[15:0])); // R6
  AST_SVID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !svid_upd[0] |=> $stable(svid_flat[15:0])); // R8
  AST_RESPONSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_local && fn_exists) |=> rsp_valid); // R11
  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_local && fn_exists && cfg_we) |=> (rsp_rdata == 32'h0)); // R11
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == 32'h0)); // R11

endmodule

bind cfg_space_target cfg_space_checker #(.NUM_FUNC(NUM_FUNC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_req   (cfg_req),
  .cfg_idsel (cfg_idsel),
  .cfg_type  (cfg_type),
  .cfg_func  (cfg_func),
  .cfg_we    (cfg_we),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .hit_vec   (hit_vec),
  .svid_upd  (svid_upd),
  .svid_flat (svid_flat),
  .cmd_flat  (cmd_flat)
);

// File: tb/cfg_space_target_test.sv
module cfg_space_target_test;

  localparam logic [15:0] VEN  = 16'h1D5A;
  localparam logic [15:0] DEV  = 16'h0C31;
  localparam logic [7:0]  REV  = 8'h02;
  localparam logic [23:0] CLS  = 24'h078000;
  localparam logic [15:0] SV0  = 16'h1D5A;
  localparam logic [15:0] SSI  = 16'hA001;
  localparam logic [15:0] SV1  = 16'h2B2B;
  localparam logic [15:0] SSI1 = 16'h0777;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, tgt = 1'b0, idsel = 1'b0, we = 1'b0;
  logic [1:0]  ty = 2'b00;
  logic [2:0]  fn = 3'd0;
  logic [5:0]  idx = 6'd0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wd = 32'h0;
  logic        rv_a, rv_b;
  logic [31:0] rd_a, rd_b;
  logic        got_v;
  logic [31:0] got_d;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_cmd  [2];
  logic [31:0] m_bar  [2];
  logic [7:0]  m_intl [2];
  logic [15:0] m_svid [2];

  always #5 clk = ~clk;

  cfg_space_target uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(req && !tgt), .cfg_idsel(idsel),
    .cfg_type(ty), .cfg_func(fn), .cfg_reg(idx), .cfg_we(we), .cfg_be(be),
    .cfg_wdata(wd), .rsp_valid(rv_a), .rsp_rdata(rd_a)
  );

  cfg_space_target #(
    .NUM_FUNC(1), .SSVID_RST(SV1), .SSID(SSI1), .SVID_MODE(cfg_pkg::SVID_WREN)
  ) uut_we (
    .clk(clk), .rst_n(rst_n), .cfg_req(req && tgt), .cfg_idsel(idsel),
    .cfg_type(ty), .cfg_func(fn), .cfg_reg(idx), .cfg_we(we), .cfg_be(be),
    .cfg_wdata(wd), .rsp_valid(rv_b), .rsp_rdata(rd_b)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic acc(input bit t, input bit sel, input logic [1:0] tp, input logic [2:0] f,
                     input logic [5:0] ix, input bit w, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    tgt = t; req = 1'b1; idsel = sel; ty = tp; fn = f; idx = ix; we = w; be = b; wd = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    got_v = t ? rv_b : rv_a;
    got_d = t ? rd_b : rd_a;
  endtask

  task automatic m_reset();
    for (int f = 0; f < 2; f++) begin
      m_cmd[f] = 16'h0; m_bar[f] = 32'h0; m_intl[f] = 8'hFF; m_svid[f] = SV0;
    end
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  // Bench model of a claimed write to the shadow-mode device.
  task automatic m_wr(input int f, input int ix, input logic [3:0] b, input logic [31:0] d);
    logic [31:0] m;
    logic [31:0] n;
    m = lanes(b);
    case (ix)
      1:  begin n = ({16'h0, m_cmd[f]} & ~m) | (d & m); m_cmd[f] = n[15:0] & 16'h0547; end
      4:  m_bar[f] = ((m_bar[f] & ~m) | (d & m)) & 32'hFFFF_F000;
      15: if (b[0]) m_intl[f] = d[7:0];
      16: if (b[1] | b[0]) begin n = ({16'h0, m_svid[f]} & ~m) | (d & m); m_svid[f] = n[15:0]; end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input int f, input int ix);
    case (ix)
      0:  return {DEV, VEN};
      1:  return {16'h0, m_cmd[f]};
      2:  return {CLS, REV};
      3:  return 32'h0080_0000;
      4:  return m_bar[f];
      11: return {SSI, m_svid[f]};
      15: return {16'h0, 8'(f + 1), m_intl[f]};
      16: return {16'h0, m_svid[f]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input int ix);
    case (ix)
      0, 2, 3: return "R3";
      1:       return "R6";
      4:       return "R5";
      11:      return "R8";
      15:      return "R7";
      16:      return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic read_all(input int f);
    for (int ix = 0; ix < 64; ix++) begin
      acc(1'b0, 1'b1, 2'b00, 3'(f), 6'(ix), 1'b0, 4'h0, 32'h0);
      chk(got_v && got_d == exp_rd(f, ix), req_of(ix), got_d, exp_rd(f, ix));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(!rv_a && rd_a == 32'h0, "R11 reset", {31'h0, rv_a}, 32'h0);

    // Reset contents of both functions.
    read_all(0);
    read_all(1);

    // R1 R2: decode sweep over select, type and function.
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 8; f++) begin
          bit cl;
          cl = (s == 1) && (t == 0) && (f < 2);
          acc(1'b0, 1'(s), 2'(t), 3'(f), 6'd0, 1'b0, 4'h0, 32'h0);
          chk(got_v == cl && got_d == (cl ? {DEV, VEN} : 32'h0), "R1 R2 decode",
              {got_v, got_d[30:0]}, {cl, 31'h0});
        end
    for (int f = 0; f < 8; f++) begin
      acc(1'b1, 1'b1, 2'b00, 3'(f), 6'd3, 1'b0, 4'h0, 32'h0);
      chk(got_v == (f == 0) && got_d == 32'h0, "R2 single-function decode", {31'h0, got_v}, {31'h0, f == 0});
    end

    // R1: unclaimed writes leave state untouched.
    acc(1'b0, 1'b0, 2'b00, 3'd0, 6'd1, 1'b1, 4'hF, 32'hFFFF_FFFF);
    acc(1'b0, 1'b1, 2'b01, 3'd0, 6'd15, 1'b1, 4'hF, 32'h0000_0000);
    acc(1'b0, 1'b1, 2'b00, 3'd5, 6'd4, 1'b1, 4'hF, 32'hFFFF_FFFF);
    acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd1, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h0, "R1 unclaimed write cmd", got_d, 32'h0);
    acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd15, 1'b0, 4'h0, 32'h0);
    chk(got_d == exp_rd(0, 15), "R1 unclaimed write intl", got_d, exp_rd(0, 15));

    // Write ones everywhere on function 0, then a pattern on function 1.
    for (int ix = 0; ix < 64; ix++) begin
      acc(1'b0, 1'b1, 2'b00, 3'd0, 6'(ix), 1'b1, 4'hF, 32'hFFFF_FFFF);
      chk(got_v && got_d == 32'h0, "R11 write response", got_d, 32'h0);
      m_wr(0, ix, 4'hF, 32'hFFFF_FFFF);
    end
    read_all(0);
    read_all(1);
    for (int ix = 0; ix < 64; ix++) begin
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'(ix), 1'b1, 4'hF, 32'hA5C3_5A3C);
      m_wr(1, ix, 4'hF, 32'hA5C3_5A3C);
    end
    read_all(0);
    read_all(1);

    // Byte-enable sweeps on writable dwords of function 1.
    for (int b = 0; b < 16; b++) begin
      logic [31:0] d;
      d = 32'h1234_5678 ^ {8{4'(b)}};
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd1, 1'b1, 4'(b), d);  m_wr(1, 1, 4'(b), d);
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd4, 1'b1, 4'(b), ~d); m_wr(1, 4, 4'(b), ~d);
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd15, 1'b1, 4'(b), d); m_wr(1, 15, 4'(b), d);
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd16, 1'b1, 4'(b), d); m_wr(1, 16, 4'(b), d);
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd1, 1'b0, 4'h0, 32'h0);
      chk(got_d == exp_rd(1, 1), "R6 byte enables", got_d, exp_rd(1, 1));
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd4, 1'b0, 4'h0, 32'h0);
      chk(got_d == exp_rd(1, 4), "R5 byte enables", got_d, exp_rd(1, 4));
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd15, 1'b0, 4'h0, 32'h0);
      chk(got_d == exp_rd(1, 15), "R7 byte enables", got_d, exp_rd(1, 15));
      acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd11, 1'b0, 4'h0, 32'h0);
      chk(got_d == exp_rd(1, 11), "R9 shadow updates header", got_d, exp_rd(1, 11));
    end

    // R5: base address patterns.
    for (int k = 0; k < 4; k++) begin
      logic [31:0] d;
      d = (k == 0) ? 32'h0000_0FFF : (k == 1) ? 32'h8000_0000 :
          (k == 2) ? 32'h0010_0000 : 32'hDEAD_BEEF;
      acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd4, 1'b1, 4'hF, d);
      acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd4, 1'b0, 4'h0, 32'h0);
      chk(got_d == (d & 32'hFFFF_F000), "R5 base address", got_d, d & 32'hFFFF_F000);
    end

    // R8: direct header write ignored in shadow mode.
    acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd11, 1'b1, 4'hF, 32'h0000_0000);
    acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd11, 1'b0, 4'h0, 32'h0);
    chk(got_d == exp_rd(0, 11), "R8 direct write ignored", got_d, exp_rd(0, 11));

    // Reset again: R6 R7 R8 reset values.
    do_reset();
    acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd1, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h0, "R6 command reset", got_d, 32'h0);
    acc(1'b0, 1'b1, 2'b00, 3'd0, 6'd15, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h0000_01FF, "R7 interrupt reset", got_d, 32'h0000_01FF);
    acc(1'b0, 1'b1, 2'b00, 3'd1, 6'd11, 1'b0, 4'h0, 32'h0);
    chk(got_d == {SSI, SV0}, "R8 subsystem reset", got_d, {SSI, SV0});

    // R10: write-enable variant (single function).
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd3, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h0, "R2 single-function header bit", got_d, 32'h0);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd16, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h0, "R10 enable reset", got_d, 32'h0);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b1, 4'hF, 32'h5555_4321);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b0, 4'h0, 32'h0);
    chk(got_d == {SSI1, SV1}, "R10 locked write ignored", got_d, {SSI1, SV1});
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd16, 1'b1, 4'h1, 32'h0000_0001);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd16, 1'b0, 4'h0, 32'h0);
    chk(got_d == 32'h1, "R10 enable set", got_d, 32'h1);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b1, 4'hF, 32'h5555_4321);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b0, 4'h0, 32'h0);
    chk(got_d == {SSI1, 16'h4321}, "R10 enabled write", got_d, {SSI1, 16'h4321});
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd16, 1'b1, 4'h1, 32'h0000_0000);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b1, 4'h3, 32'h0000_9999);
    acc(1'b1, 1'b1, 2'b00, 3'd0, 6'd11, 1'b0, 4'h0, 32'h0);
    chk(got_d == {SSI1, 16'h4321}, "R10 relocked write ignored", got_d, {SSI1, 16'h4321});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule